// File: doc/BRIEF.md
# Masked Burst Address Generator

This block produces the internal address for one port of a synchronous memory. The host loads a start address once. The block then steps the address by itself on every clock that has count enable asserted. A mask register confines the stepping to a low-order field of the address, and the bits above that field stay frozen. When the field has reached all ones, the next step reloads the whole address from a mirror of the last loaded start address. A burst therefore repeats over the same window and never falls back to zero.

A terminal-count flag, active low, marks each step that brings the field to its limit. The control strobes are active low and follow a fixed priority: master reset, counter reset, mask load, address load, increment, hold. A readback path returns either the counter or the mask on a registered output with a valid flag. The memory array and the bidirectional pads are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: After master reset (`rst_n` low) the address is 0, the mirror is 0, the mask is all ones and `term_n_o` is 1.
- R2: With `cnt_rst_n` high, `load_n` low and `mask_sel_n` high, the address on `addr_i` appears on `int_addr_o` after that same clock edge, with no dead cycle. The mirror captures the same value.
- R3: Increment (`cnt_en_n` low, `load_n` high, `mask_sel_n` high, `cnt_rst_n` high) with mask bit 0 set adds one inside the field where the mask bits are 1. Bits where the mask is 0 do not change.
- R4: When mask bit 0 is 0, an increment adds two, and address bit 0 keeps its value.
- R5: An increment applied while every address bit under the mask is 1 loads the mirror value into the address.
- R6: `term_n_o` is 0 exactly in the cycle after an increment whose result has every masked bit at 1. After any other operation it is 1.
- R7: When none of `cnt_rst_n`, `load_n` or `cnt_en_n` is low, the counter, the mask and the mirror all keep their values.
- R8: A low `cnt_rst_n` sets the address to 0 and the mask to all ones, and leaves the mirror unchanged.
- R9: With `mask_sel_n` low and `load_n` low, `addr_i` is written into the mask. The counter and the mirror stay unchanged.
- R10: Priority runs in this order: counter reset, then mask load, then address load, then increment. When `mask_sel_n` is low and `load_n` is high, the operation is a hold, whatever `cnt_en_n` is.
- R11: A low `rdbk_n` at an edge makes `rdbk_vld_o` 1 after that edge. `rdbk_data_o` then shows the counter (`mask_sel_n` high) or the mask (`mask_sel_n` low) as they were before that edge. Without a readback request, `rdbk_vld_o` and `rdbk_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous master reset, active low |
| addr_i | input | ADDR_W | External address or mask value |
| load_n | input | 1 | Load strobe, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| cnt_rst_n | input | 1 | Counter reset, active low |
| mask_sel_n | input | 1 | Selects the mask for loading and readback, active low |
| rdbk_n | input | 1 | Readback request, active low |
| int_addr_o | output | ADDR_W | Current internal address |
| term_n_o | output | 1 | Terminal-count flag, active low |
| rdbk_data_o | output | ADDR_W | Readback value |
| rdbk_vld_o | output | 1 | Readback valid |

## Verification
The bench aims at the wrap point. A step from an all-ones field must return to the mirror and not to zero or to the masked base. A design that wrapped wrongly would restart the burst at the wrong address. The bench uses masks of the two legal shapes and many widths. A mask with bit 0 clear catches a counter that steps by one or that disturbs bit 0. A single-bit mask catches an off-by-one limit. The bench also drives conflicting strobes together. A wrong priority order then shows up as a wrong counter or a wrong mask, which the bench can see through readback. A master reset in the middle of a burst must clear a flag that is pending.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   typedef enum logic [2:0] {
      OP_HOLD  = 3'd0,
      OP_CRST  = 3'd1,
      OP_MLOAD = 3'd2,
      OP_LOAD  = 3'd3,
      OP_INC   = 3'd4
   } burst_op_e;
endpackage

// File: rtl/burst_ctrl_dec.sv
module burst_ctrl_dec
   import burst_addr_pkg::*;
(
   input  logic      load_n,
   input  logic      cnt_en_n,
   input  logic      cnt_rst_n,
   input  logic      mask_sel_n,
   output burst_op_e op_o
);
   // fixed priority: counter reset > mask load > address load > increment > hold
   always_comb begin
      if (!cnt_rst_n)                     op_o = OP_CRST;
      else if (!load_n && !mask_sel_n)    op_o = OP_MLOAD;
      else if (!load_n)                   op_o = OP_LOAD;
      else if (!cnt_en_n && mask_sel_n)   op_o = OP_INC;
      else                                op_o = OP_HOLD;
   end
endmodule

// File: rtl/burst_step.sv
module burst_step #(
   parameter int ADDR_W = 18
) (
   input  logic [ADDR_W-1:0] cnt_i,
   input  logic [ADDR_W-1:0] mask_i,
   input  logic [ADDR_W-1:0] mirror_i,
   output logic [ADDR_W-1:0] nxt_o,
   output logic              at_top_o,
   output logic              hits_top_o
);
   localparam int PAD_W = ADDR_W - 2;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("burst_step: ADDR_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] unit;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] stepped;

   // step size is two when the lowest bit is excluded from the field
   assign unit     = {{PAD_W{1'b0}}, ~mask_i[0], mask_i[0]};
   assign sum      = cnt_i + unit;
   assign at_top_o = ((cnt_i & mask_i) == mask_i);

   genvar b;
   generate
      for (b = 0; b < ADDR_W; b++) begin : g_bit
         assign stepped[b] = mask_i[b] ? sum[b] : cnt_i[b];
         assign nxt_o[b]   = at_top_o ? mirror_i[b] : stepped[b];
      end
   endgenerate

   assign hits_top_o = ((nxt_o & mask_i) == mask_i);
endmodule

// File: rtl/burst_readback.sv
module burst_readback #(
   parameter int ADDR_W     = 18,
   parameter bit CLEAR_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_n,
   input  logic              sel_mask_n,
   input  logic [ADDR_W-1:0] cnt_i,
   input  logic [ADDR_W-1:0] mask_i,
   output logic [ADDR_W-1:0] data_o,
   output logic              vld_o
);
   logic [ADDR_W-1:0] pick;
   assign pick = sel_mask_n ? cnt_i : mask_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_o <= 1'b0;
      else        vld_o <= ~req_n;
   end

   generate
      if (CLEAR_IDLE) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     data_o <= '0;
            else if (!req_n) data_o <= pick;
            else            data_o <= '0;
         end
      end else begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      data_o <= '0;
            else if (!req_n) data_o <= pick;
         end
      end
   endgenerate

   AST_RDBK_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !req_n |=> vld_o) else $error("readback valid missing"); // R11
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
   import burst_addr_pkg::*;
#(
   parameter int ADDR_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              load_n,
   input  logic              cnt_en_n,
   input  logic              cnt_rst_n,
   input  logic              mask_sel_n,
   input  logic              rdbk_n,
   output logic [ADDR_W-1:0] int_addr_o,
   output logic              term_n_o,
   output logic [ADDR_W-1:0] rdbk_data_o,
   output logic              rdbk_vld_o
);
   localparam logic [ADDR_W-1:0] ALL_ONES = '1;

   generate
      if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_width
         $error("burst_addr_gen: ADDR_W out of range 2..32");
      end
   endgenerate

   burst_op_e         op;
   logic [ADDR_W-1:0] cnt_q, mask_q, mir_q, nxt;
   logic              at_top, hits_top, term_n_q;

   burst_ctrl_dec u_dec (
      .load_n     (load_n),
      .cnt_en_n   (cnt_en_n),
      .cnt_rst_n  (cnt_rst_n),
      .mask_sel_n (mask_sel_n),
      .op_o       (op)
   );

   burst_step #(.ADDR_W(ADDR_W)) u_step (
      .cnt_i      (cnt_q),
      .mask_i     (mask_q),
      .mirror_i   (mir_q),
      .nxt_o      (nxt),
      .at_top_o   (at_top),
      .hits_top_o (hits_top)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         mask_q   <= ALL_ONES;
         mir_q    <= '0;
         term_n_q <= 1'b1;
      end else begin
         term_n_q <= 1'b1;
         unique case (op)
            OP_CRST: begin
               cnt_q  <= '0;
               mask_q <= ALL_ONES;
            end
            OP_MLOAD: mask_q <= addr_i;
            OP_LOAD: begin
               cnt_q <= addr_i;
               mir_q <= addr_i;
            end
            OP_INC: begin
               cnt_q    <= nxt;
               term_n_q <= ~hits_top;
            end
            default: ;
         endcase
      end
   end

   burst_readback #(.ADDR_W(ADDR_W), .CLEAR_IDLE(1'b1)) u_rdbk (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_n      (rdbk_n),
      .sel_mask_n (mask_sel_n),
      .cnt_i      (cnt_q),
      .mask_i     (mask_q),
      .data_o     (rdbk_data_o),
      .vld_o      (rdbk_vld_o)
   );

   assign int_addr_o = cnt_q;
   assign term_n_o   = term_n_q;

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_LOAD) |=> (cnt_q == $past(addr_i)) && (mir_q == $past(addr_i))) else $error("load"); // R2
   AST_FROZEN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INC && !at_top) |=> (((cnt_q ^ $past(cnt_q)) & ~$past(mask_q)) == '0)) else $error("frozen"); // R3
   AST_WRAP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_INC && at_top) |=> (cnt_q == $past(mir_q))) else $error("wrap"); // R5
   AST_TERM_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      !term_n_q |-> ((cnt_q & mask_q) == mask_q)) else $error("term"); // R6
   AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_HOLD) |=> $stable(cnt_q) && $stable(mask_q) && $stable(mir_q)) else $error("hold"); // R7
   AST_CRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CRST) |=> (cnt_q == '0) && (mask_q == ALL_ONES) && $stable(mir_q)) else $error("crst"); // R8
   AST_MLOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_MLOAD) |=> (mask_q == $past(addr_i)) && $stable(cnt_q) && $stable(mir_q)) else $error("mload"); // R9
endmodule

// File: tb/burst_addr_gen_tb_top.sv
module burst_addr_gen_tb_top;
   localparam int AW = 18;
   localparam logic [AW-1:0] ONES = '1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic load_n = 1'b1, cnt_en_n = 1'b1, cnt_rst_n = 1'b1, mask_sel_n = 1'b1, rdbk_n = 1'b1;
   logic [AW-1:0] int_addr_o, rdbk_data_o;
   logic term_n_o, rdbk_vld_o;

   int checks = 0, errors = 0;
   bit done = 0;

   // reference state
   logic [AW-1:0] m_cnt, m_mask, m_mir, m_rd;
   logic m_term, m_rv;
   string last_tag;

   always #10 clk = ~clk;

   burst_addr_gen #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .load_n(load_n), .cnt_en_n(cnt_en_n),
      .cnt_rst_n(cnt_rst_n), .mask_sel_n(mask_sel_n), .rdbk_n(rdbk_n),
      .int_addr_o(int_addr_o), .term_n_o(term_n_o),
      .rdbk_data_o(rdbk_data_o), .rdbk_vld_o(rdbk_vld_o)
   );

   task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference, advanced once per rising edge
   task automatic model_edge();
      logic [AW-1:0] step;
      if (!rst_n) begin
         m_cnt = '0; m_mask = ONES; m_mir = '0; m_term = 1; m_rv = 0; m_rd = '0;
         last_tag = "R1";
         return;
      end
      m_rv = !rdbk_n;
      m_rd = !rdbk_n ? (mask_sel_n ? m_cnt : m_mask) : '0;
      m_term = 1;
      if (!cnt_rst_n) begin
         m_cnt = '0; m_mask = ONES; last_tag = "R8";
      end else if (!load_n && !mask_sel_n) begin
         m_mask = addr_i; last_tag = "R9";
      end else if (!load_n) begin
         m_cnt = addr_i; m_mir = addr_i; last_tag = "R2";
      end else if (!cnt_en_n && mask_sel_n) begin
         if ((m_cnt & m_mask) == m_mask) begin
            m_cnt = m_mir; last_tag = "R5";
         end else begin
            step = m_mask[0] ? 1 : 2;
            m_cnt = (m_cnt & ~m_mask) | ((m_cnt + step) & m_mask);
            last_tag = m_mask[0] ? "R3" : "R4";
         end
         m_term = ((m_cnt & m_mask) != m_mask);
      end else begin
         last_tag = (!mask_sel_n && !cnt_en_n) ? "R10" : "R7";
      end
   endtask

   task automatic cycle();
      @(posedge clk);
      model_edge();
      #1;
      chk(last_tag, int_addr_o, m_cnt);
      chk("R6", AW'(term_n_o), AW'(m_term));
      chk("R11", AW'(rdbk_vld_o), AW'(m_rv));
      chk("R11", rdbk_data_o, m_rd);
   endtask

   task automatic idle();
      load_n = 1; cnt_en_n = 1; cnt_rst_n = 1; mask_sel_n = 1; rdbk_n = 1;
   endtask

   function automatic logic [AW-1:0] legal_mask(int n, bit even);
      logic [AW-1:0] m;
      m = ONES >> (AW - n);
      if (even && n >= 2) m[0] = 1'b0;
      return m;
   endfunction

   task automatic read_mask(logic [AW-1:0] exp, string req);
      idle(); mask_sel_n = 0; rdbk_n = 0; cycle();
      chk(req, rdbk_data_o, exp);
      idle();
   endtask

   initial begin
      m_cnt = '0; m_mask = ONES; m_mir = '0; m_term = 1; m_rv = 0; m_rd = '0; last_tag = "R1";
      idle();
      #35;
      chk("R1", int_addr_o, '0);
      chk("R1", AW'(term_n_o), AW'(1));
      rst_n = 1;
      read_mask(ONES, "R1");

      // window 8..3F, retransmit
      idle(); mask_sel_n = 0; load_n = 0; addr_i = 'h3F; cycle();
      idle(); load_n = 0; addr_i = 'h8; cycle();
      chk("R2", int_addr_o, 'h8);
      idle(); cnt_en_n = 0;
      for (int i = 0; i < 'h37; i++) cycle();
      chk("R6", int_addr_o, 'h3F);
      chk("R6", AW'(term_n_o), AW'(0));
      cycle();
      chk("R5", int_addr_o, 'h8);
      chk("R6", AW'(term_n_o), AW'(1));

      // step by two with bit 0 excluded, high bits frozen
      idle(); mask_sel_n = 0; load_n = 0; addr_i = 'h6; cycle();
      idle(); load_n = 0; addr_i = 'h30003; cycle();
      idle(); cnt_en_n = 0; cycle();
      chk("R4", int_addr_o, 'h30005);
      cycle();
      chk("R4", int_addr_o, 'h30007);
      chk("R6", AW'(term_n_o), AW'(0));
      cycle();
      chk("R5", int_addr_o, 'h30003);

      // hold and masked-select hold
      idle(); cycle(); cycle();
      chk("R7", int_addr_o, 'h30003);
      idle(); mask_sel_n = 0; cnt_en_n = 0; cycle();
      chk("R10", int_addr_o, 'h30003);

      // all strobes together: counter reset wins, mirror kept
      idle(); cnt_rst_n = 0; load_n = 0; mask_sel_n = 0; cnt_en_n = 0; addr_i = 'h1; cycle();
      chk("R8", int_addr_o, '0);
      read_mask(ONES, "R10");
      // mask load beats address load; counter unchanged
      idle(); load_n = 0; mask_sel_n = 0; cnt_en_n = 0; addr_i = 'h1; cycle();
      chk("R9", int_addr_o, '0);
      read_mask('h1, "R9");
      // mirror still 30003 after counter reset: single-bit field wraps to it
      idle(); cnt_en_n = 0; cycle();
      chk("R3", int_addr_o, 'h1);
      chk("R6", AW'(term_n_o), AW'(0));
      cycle();
      chk("R8", int_addr_o, 'h30003);

      // randomized legal traffic
      for (int k = 0; k < 3000; k++) begin
         int r;
         idle();
         r = $urandom_range(0, 99);
         rdbk_n = ($urandom_range(0, 3) != 0);
         mask_sel_n = ($urandom_range(0, 5) != 0);
         addr_i = AW'($urandom);
         if (r < 4) cnt_rst_n = 0;
         else if (r < 10) begin
            load_n = 0; mask_sel_n = 0;
            addr_i = legal_mask($urandom_range(1, 6), $urandom_range(0, 1) == 1);
         end else if (r < 18) load_n = 0;
         else if (r < 88) cnt_en_n = 0;
         if (k == 1500) begin
            cycle();
            rst_n = 0; #2;
            chk("R1", int_addr_o, '0);
            chk("R1", AW'(term_n_o), AW'(1));
            idle(); cycle();
            rst_n = 1;
         end else begin
            cycle();
         end
      end

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule